// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

The router collects the interrupt sources that belong to each processor core and delivers them to that core's IRQ and FIQ inputs. Each core has four timer lines and four mailbox-pending lines of its own. One shared GPU line and one PMU line can be delivered to any core. The timer counters and the mailbox storage sit outside this block, and their outputs arrive here as plain level inputs.

A 32-bit register port sets up all routing. The port uses word offsets inside a 0x100-byte window. Each core has a timer configuration word and a mailbox configuration word. Both words use the same layout: four IRQ enables in the low nibble and four FIQ enables in the next nibble. A single GPU routing word picks one core for the IRQ copy of the GPU line and one core for the FIQ copy. PMU routing is an 8-bit state that software changes only through a write-1-to-set offset and a write-1-to-clear offset. Each core also has a read-only pending word, which shows the sources currently asserting toward that core. When a source is enabled for both IRQ and FIQ on the same core, it is delivered as FIQ only.

Register writes take effect at the next clock edge. Reads, pending bits and the IRQ/FIQ outputs are combinational.

Top module: `lirq_router`

## Requirements
- R1: After reset, the control word reads 0, the prescaler reads 0x80000000, and the GPU routing, PMU routing, timer configuration and mailbox configuration words all read 0. With the GPU line low, no core raises IRQ or FIQ, whatever the other levels are.
- R2: Offsets 0x00 (control) and 0x08 (prescaler) keep all 32 written bits. Offset 0x0C keeps bits [3:0]. The timer configuration of core n at 0x40+4n and the mailbox configuration of core n at 0x50+4n keep bits [7:0]. All other bits of these words read 0.
- R3: A write to 0x10 sets every PMU routing bit that is written as 1. A write to 0x14 clears every PMU routing bit that is written as 1. Bits written as 0 leave the state unchanged, and both offsets read back the 8-bit state.
- R4: In a core's timer configuration, bit n (n = 0..3) enables IRQ for timer n and bit 4+n enables FIQ for timer n. The core's FIQ output is the OR of its sources that are FIQ-enabled and high. Its IRQ output is the OR of its sources that are IRQ-enabled, high and not FIQ-enabled.
- R5: The mailbox configuration uses the same layout as the timer configuration. Bit n enables IRQ and bit 4+n enables FIQ for mailbox line n of that core.
- R6: GPU routing bits [1:0] give the index of the core that receives the GPU line as IRQ. Bits [3:2] give the index of the core that receives it as FIQ.
- R7: A source enabled for both IRQ and FIQ on one core raises only that core's FIQ, and its pending bit is still set.
- R8: The pending word of core n, at 0x60+4n, uses this layout: bits 0-3 for timers 0-3, bits 4-7 for mailboxes 0-3, bit 8 for GPU and bit 9 for PMU. A bit is 1 when the source level is high and the source is routed to that core as IRQ or FIQ. The bit follows the level in the same cycle, and bits 31:10 read 0.
- R9: Writes to the pending offsets change no state.
- R10: Reads return 0 in three cases: an offset outside the map, an offset that is not word-aligned, and a per-core offset for a core index at or above the core count. Writes to such offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| timer_lvl | input | NUM_CORES*4 | Timer levels; core c timer n on bit 4c+n |
| mbox_lvl | input | NUM_CORES*4 | Mailbox-pending levels; core c mailbox n on bit 4c+n |
| gpu_lvl | input | 1 | Shared GPU interrupt level |
| pmu_lvl | input | 1 | PMU interrupt level |
| core_irq | output | NUM_CORES | IRQ output per core |
| core_fiq | output | NUM_CORES | FIQ output per core |

## Verification
The bench builds the router with its defaults: four cores and an 8-bit offset. With these values every per-core offset up to 0x6C decodes, and every 2-bit GPU core index names a real core. At this width the decoder variant without upper offset bits is the one used. The bench therefore reaches the cases where the IRQ core and the FIQ core differ or coincide, PMU bits that mix IRQ and FIQ across cores, and unaligned or gap offsets next to mapped words.

// File: rtl/lirq_pkg.sv
`timescale 1ns/1ps
package lirq_pkg;

   localparam int unsigned LIRQ_DW     = 32;
   localparam int unsigned LIRQ_SRC_W  = 10;
   localparam int unsigned LIRQ_LANES  = 4;
   localparam int unsigned LIRQ_CFG_W  = 2 * LIRQ_LANES;
   localparam int unsigned LIRQ_MAX_CORES = 4;

   localparam int unsigned PB_TMR  = 0;
   localparam int unsigned PB_MBX  = 4;
   localparam int unsigned PB_GPU  = 8;
   localparam int unsigned PB_PMU  = 9;

   localparam logic [31:0] PRESC_DEFAULT = 32'h8000_0000;

   typedef enum logic [3:0] {
      K_NONE,
      K_CTRL,
      K_PRESC,
      K_GPU,
      K_PSET,
      K_PCLR,
      K_TMR,
      K_MBX,
      K_PEND
   } lirq_kind_e;

   typedef struct packed {
      lirq_kind_e  kind;
      logic [1:0]  idx;
   } lirq_sel_t;

endpackage

// File: rtl/lirq_decode.sv
`timescale 1ns/1ps
module lirq_decode
   import lirq_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned ADDR_W    = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output lirq_sel_t         sel
);

   logic in_window;

   generate
      if (ADDR_W > 8) begin : g_wide
         assign in_window = ~|addr[ADDR_W-1:8];
      end else begin : g_narrow
         assign in_window = 1'b1;
      end
   endgenerate

   logic core_ok;
   assign core_ok = (32'(addr[3:2]) < NUM_CORES);

   always_comb begin
      sel.kind = K_NONE;
      sel.idx  = addr[3:2];
      if (in_window && addr[1:0] == 2'b00) begin
         unique case (addr[7:4])
            4'h0: begin
               case (addr[3:2])
                  2'd0:    sel.kind = K_CTRL;
                  2'd2:    sel.kind = K_PRESC;
                  2'd3:    sel.kind = K_GPU;
                  default: sel.kind = K_NONE;
               endcase
            end
            4'h1: begin
               case (addr[3:2])
                  2'd0:    sel.kind = K_PSET;
                  2'd1:    sel.kind = K_PCLR;
                  default: sel.kind = K_NONE;
               endcase
            end
            4'h4:    sel.kind = core_ok ? K_TMR  : K_NONE;
            4'h5:    sel.kind = core_ok ? K_MBX  : K_NONE;
            4'h6:    sel.kind = core_ok ? K_PEND : K_NONE;
            default: sel.kind = K_NONE;
         endcase
      end
   end

endmodule

// File: rtl/lirq_regs.sv
`timescale 1ns/1ps
module lirq_regs
   import lirq_pkg::*;
#(
   parameter int unsigned NUM_CORES   = 4,
   parameter logic [31:0] PRESCALE_RST = PRESC_DEFAULT
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   we,
   input  lirq_sel_t                              sel,
   input  logic [LIRQ_DW-1:0]                     wdata,
   input  logic [NUM_CORES-1:0][LIRQ_SRC_W-1:0]   pend,
   output logic [LIRQ_DW-1:0]                     rdata,
   output logic [3:0]                             gpu_route,
   output logic [LIRQ_CFG_W-1:0]                  pmu_route,
   output logic [NUM_CORES-1:0][LIRQ_CFG_W-1:0]   tmr_cfg,
   output logic [NUM_CORES-1:0][LIRQ_CFG_W-1:0]   mbx_cfg
);

   logic [LIRQ_DW-1:0] ctrl_q;
   logic [LIRQ_DW-1:0] presc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         presc_q   <= PRESCALE_RST;
         gpu_route <= '0;
         pmu_route <= '0;
      end else if (we) begin
         case (sel.kind)
            K_CTRL:  ctrl_q    <= wdata;
            K_PRESC: presc_q   <= wdata;
            K_GPU:   gpu_route <= wdata[3:0];
            K_PSET:  pmu_route <= pmu_route | wdata[LIRQ_CFG_W-1:0];
            K_PCLR:  pmu_route <= pmu_route & ~wdata[LIRQ_CFG_W-1:0];
            default: ;
         endcase
      end
   end

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      logic hit;
      assign hit = we && (sel.idx == 2'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tmr_cfg[c] <= '0;
            mbx_cfg[c] <= '0;
         end else if (hit) begin
            if (sel.kind == K_TMR) tmr_cfg[c] <= wdata[LIRQ_CFG_W-1:0];
            if (sel.kind == K_MBX) mbx_cfg[c] <= wdata[LIRQ_CFG_W-1:0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      case (sel.kind)
         K_CTRL:  rdata = ctrl_q;
         K_PRESC: rdata = presc_q;
         K_GPU:   rdata = {28'd0, gpu_route};
         K_PSET,
         K_PCLR:  rdata = {{(LIRQ_DW-LIRQ_CFG_W){1'b0}}, pmu_route};
         K_TMR, K_MBX, K_PEND: begin
            for (int c = 0; c < NUM_CORES; c++) begin
               if (sel.idx == 2'(c)) begin
                  if (sel.kind == K_TMR)
                     rdata = {{(LIRQ_DW-LIRQ_CFG_W){1'b0}}, tmr_cfg[c]};
                  else if (sel.kind == K_MBX)
                     rdata = {{(LIRQ_DW-LIRQ_CFG_W){1'b0}}, mbx_cfg[c]};
                  else
                     rdata = {{(LIRQ_DW-LIRQ_SRC_W){1'b0}}, pend[c]};
               end
            end
         end
         default: rdata = '0;
      endcase
   end

endmodule

// File: rtl/lirq_core_route.sv
`timescale 1ns/1ps
module lirq_core_route
   import lirq_pkg::*;
(
   input  logic [LIRQ_LANES-1:0] tmr_lvl,
   input  logic [LIRQ_LANES-1:0] mbx_lvl,
   input  logic                  gpu_lvl,
   input  logic                  pmu_lvl,
   input  logic [LIRQ_CFG_W-1:0] tmr_cfg,
   input  logic [LIRQ_CFG_W-1:0] mbx_cfg,
   input  logic                  gpu_to_irq,
   input  logic                  gpu_to_fiq,
   input  logic                  pmu_to_irq,
   input  logic                  pmu_to_fiq,
   output logic [LIRQ_SRC_W-1:0] pend,
   output logic                  irq,
   output logic                  fiq
);

   logic [LIRQ_SRC_W-1:0] lvl;
   logic [LIRQ_SRC_W-1:0] en_irq;
   logic [LIRQ_SRC_W-1:0] en_fiq;

   assign lvl    = {pmu_lvl, gpu_lvl, mbx_lvl, tmr_lvl};
   assign en_irq = {pmu_to_irq, gpu_to_irq,
                    mbx_cfg[LIRQ_LANES-1:0], tmr_cfg[LIRQ_LANES-1:0]};
   assign en_fiq = {pmu_to_fiq, gpu_to_fiq,
                    mbx_cfg[LIRQ_CFG_W-1:LIRQ_LANES], tmr_cfg[LIRQ_CFG_W-1:LIRQ_LANES]};

   // a source routed both ways counts toward FIQ only
   assign pend = lvl & (en_irq | en_fiq);
   assign fiq  = |(lvl & en_fiq);
   assign irq  = |(lvl & en_irq & ~en_fiq);

endmodule

// File: rtl/lirq_router.sv
`timescale 1ns/1ps
module lirq_router
   import lirq_pkg::*;
#(
   parameter int unsigned NUM_CORES    = 4,
   parameter int unsigned ADDR_W       = 8,
   parameter logic [31:0] PRESCALE_RST = PRESC_DEFAULT
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              reg_we,
   input  logic [ADDR_W-1:0]                 reg_addr,
   input  logic [31:0]                       reg_wdata,
   output logic [31:0]                       reg_rdata,
   input  logic [NUM_CORES*LIRQ_LANES-1:0]   timer_lvl,
   input  logic [NUM_CORES*LIRQ_LANES-1:0]   mbox_lvl,
   input  logic                              gpu_lvl,
   input  logic                              pmu_lvl,
   output logic [NUM_CORES-1:0]              core_irq,
   output logic [NUM_CORES-1:0]              core_fiq
);

   generate
      if (NUM_CORES < 1 || NUM_CORES > LIRQ_MAX_CORES) begin : g_bad_cores
         $error("lirq_router: NUM_CORES must be 1..4");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("lirq_router: ADDR_W must cover a 0x100 window");
      end
   endgenerate

   lirq_sel_t                             sel;
   logic [NUM_CORES-1:0][LIRQ_SRC_W-1:0]  pend;
   logic [3:0]                            gpu_route;
   logic [LIRQ_CFG_W-1:0]                 pmu_route;
   logic [NUM_CORES-1:0][LIRQ_CFG_W-1:0]  tmr_cfg;
   logic [NUM_CORES-1:0][LIRQ_CFG_W-1:0]  mbx_cfg;

   lirq_decode #(
      .NUM_CORES (NUM_CORES),
      .ADDR_W    (ADDR_W)
   ) u_decode (
      .addr (reg_addr),
      .sel  (sel)
   );

   lirq_regs #(
      .NUM_CORES    (NUM_CORES),
      .PRESCALE_RST (PRESCALE_RST)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .we        (reg_we),
      .sel       (sel),
      .wdata     (reg_wdata),
      .pend      (pend),
      .rdata     (reg_rdata),
      .gpu_route (gpu_route),
      .pmu_route (pmu_route),
      .tmr_cfg   (tmr_cfg),
      .mbx_cfg   (mbx_cfg)
   );

   for (genvar c = 0; c < NUM_CORES; c++) begin : g_route
      lirq_core_route u_core (
         .tmr_lvl    (timer_lvl[c*LIRQ_LANES +: LIRQ_LANES]),
         .mbx_lvl    (mbox_lvl[c*LIRQ_LANES +: LIRQ_LANES]),
         .gpu_lvl    (gpu_lvl),
         .pmu_lvl    (pmu_lvl),
         .tmr_cfg    (tmr_cfg[c]),
         .mbx_cfg    (mbx_cfg[c]),
         .gpu_to_irq (gpu_route[1:0] == 2'(c)),
         .gpu_to_fiq (gpu_route[3:2] == 2'(c)),
         .pmu_to_irq (pmu_route[c]),
         .pmu_to_fiq (pmu_route[LIRQ_LANES + c]),
         .pend       (pend[c]),
         .irq        (core_irq[c]),
         .fiq        (core_fiq[c])
      );
   end

endmodule

// File: rtl/lirq_router_chk.sv
`timescale 1ns/1ps
module lirq_router_chk #(
   parameter int unsigned NUM_CORES = 4,
   parameter int unsigned ADDR_W    = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    reg_we,
   input logic [ADDR_W-1:0]       reg_addr,
   input logic [31:0]             reg_wdata,
   input logic [31:0]             reg_rdata,
   input logic [NUM_CORES*4-1:0]  timer_lvl,
   input logic [NUM_CORES*4-1:0]  mbox_lvl,
   input logic                    gpu_lvl,
   input logic                    pmu_lvl,
   input logic [NUM_CORES-1:0]    core_irq,
   input logic [NUM_CORES-1:0]    core_fiq,
   input logic [7:0]              pmu_route
);

   function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
      int unsigned o;
      o = int'(a);
      if (o[1:0] != 2'b00) return 1'b0;
      if (o == 32'h00 || o == 32'h08 || o == 32'h0C || o == 32'h10 || o == 32'h14)
         return 1'b1;
      if (o >= 32'h40 && o < 32'h40 + 4 * NUM_CORES) return 1'b1;
      if (o >= 32'h50 && o < 32'h50 + 4 * NUM_CORES) return 1'b1;
      if (o >= 32'h60 && o < 32'h60 + 4 * NUM_CORES) return 1'b1;
      return 1'b0;
   endfunction

   logic wr_set, wr_clr;
   assign wr_set = reg_we && (int'(reg_addr) == 32'h10);
   assign wr_clr = reg_we && (int'(reg_addr) == 32'h14);

   assert_pmu_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> ((pmu_route & $past(reg_wdata[7:0])) == $past(reg_wdata[7:0])));

   assert_pmu_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> ((pmu_route & $past(reg_wdata[7:0])) == 8'h00));

   assert_pmu_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_set || wr_clr) |=> $stable(pmu_route));

   assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !is_mapped(reg_addr) |-> (reg_rdata == 32'h0));

   assert_quiet_inputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (timer_lvl == '0 && mbox_lvl == '0 && !gpu_lvl && !pmu_lvl)
         |-> (core_irq == '0 && core_fiq == '0));

endmodule

bind lirq_router lirq_router_chk #(
   .NUM_CORES (NUM_CORES),
   .ADDR_W    (ADDR_W)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .timer_lvl (timer_lvl),
   .mbox_lvl  (mbox_lvl),
   .gpu_lvl   (gpu_lvl),
   .pmu_lvl   (pmu_lvl),
   .core_irq  (core_irq),
   .core_fiq  (core_fiq),
   .pmu_route (pmu_route)
);

// File: tb/test_lirq_router.sv
`timescale 1ns/1ps
module test_lirq_router;

   localparam int NC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [15:0] timer_lvl = '0;
   logic [15:0] mbox_lvl = '0;
   logic        gpu_lvl = 1'b0;
   logic        pmu_lvl = 1'b0;
   logic [3:0]  core_irq, core_fiq;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   lirq_router i_lirq_router (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .timer_lvl (timer_lvl),
      .mbox_lvl  (mbox_lvl),
      .gpu_lvl   (gpu_lvl),
      .pmu_lvl   (pmu_lvl),
      .core_irq  (core_irq),
      .core_fiq  (core_fiq)
   );

   typedef struct packed {
      logic        we;
      logic [7:0]  a;
      logic [31:0] d;
      logic [31:0] e;
      logic [7:0]  r;
   } vec_t;

   localparam int NV = 33;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 8'h00, 32'h0,         32'h0000_0000, 8'd1},  // R1
      '{1'b0, 8'h08, 32'h0,         32'h8000_0000, 8'd1},  // R1
      '{1'b0, 8'h0C, 32'h0,         32'h0000_0000, 8'd1},  // R1
      '{1'b0, 8'h10, 32'h0,         32'h0000_0000, 8'd1},  // R1
      '{1'b0, 8'h40, 32'h0,         32'h0000_0000, 8'd1},  // R1
      '{1'b0, 8'h5C, 32'h0,         32'h0000_0000, 8'd1},  // R1
      '{1'b1, 8'h00, 32'hDEAD_BEEF, 32'h0,         8'd2},  // R2
      '{1'b0, 8'h00, 32'h0,         32'hDEAD_BEEF, 8'd2},
      '{1'b1, 8'h08, 32'h1234_5678, 32'h0,         8'd2},
      '{1'b0, 8'h08, 32'h0,         32'h1234_5678, 8'd2},
      '{1'b1, 8'h0C, 32'hFFFF_FFFF, 32'h0,         8'd2},
      '{1'b0, 8'h0C, 32'h0,         32'h0000_000F, 8'd2},
      '{1'b1, 8'h44, 32'hFFFF_FFA5, 32'h0,         8'd2},
      '{1'b0, 8'h44, 32'h0,         32'h0000_00A5, 8'd2},
      '{1'b1, 8'h58, 32'h0000_003C, 32'h0,         8'd2},
      '{1'b0, 8'h58, 32'h0,         32'h0000_003C, 8'd2},
      '{1'b1, 8'h10, 32'h0000_0021, 32'h0,         8'd3},  // R3
      '{1'b0, 8'h10, 32'h0,         32'h0000_0021, 8'd3},
      '{1'b1, 8'h10, 32'hFFFF_FF84, 32'h0,         8'd3},
      '{1'b0, 8'h14, 32'h0,         32'h0000_00A5, 8'd3},
      '{1'b1, 8'h14, 32'h0000_0001, 32'h0,         8'd3},
      '{1'b0, 8'h10, 32'h0,         32'h0000_00A4, 8'd3},
      '{1'b1, 8'h14, 32'h0000_0000, 32'h0,         8'd3},
      '{1'b0, 8'h10, 32'h0,         32'h0000_00A4, 8'd3},
      '{1'b0, 8'h04, 32'h0,         32'h0000_0000, 8'd10}, // R10
      '{1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0,         8'd10},
      '{1'b0, 8'h04, 32'h0,         32'h0000_0000, 8'd10},
      '{1'b0, 8'h02, 32'h0,         32'h0000_0000, 8'd10},
      '{1'b0, 8'h70, 32'h0,         32'h0000_0000, 8'd10},
      '{1'b1, 8'h60, 32'hFFFF_FFFF, 32'h0,         8'd9},  // R9
      '{1'b0, 8'h60, 32'h0,         32'h0000_0000, 8'd9},
      '{1'b0, 8'h00, 32'h0,         32'hDEAD_BEEF, 8'd9},
      '{1'b0, 8'h10, 32'h0,         32'h0000_00A4, 8'd9}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      #1 reg_we = 1'b0;
   endtask

   task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1 chk(tag, reg_rdata, exp);
   endtask

   task automatic outs(input string tag, input logic [3:0] ei, input logic [3:0] ef);
      #1;
      chk({tag, " irq"}, {28'd0, core_irq}, {28'd0, ei});
      chk({tag, " fiq"}, {28'd0, core_fiq}, {28'd0, ef});
   endtask

   task automatic quiet();
      timer_lvl = '0; mbox_lvl = '0; gpu_lvl = 1'b0; pmu_lvl = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      do_reset();

      // table walk: register behaviour with all levels low
      for (int i = 0; i < NV; i++) begin
         if (VECS[i].we)
            wr(VECS[i].a, VECS[i].d);
         else
            rd($sformatf("R%0d vec%0d", VECS[i].r, i), VECS[i].a, VECS[i].e);
      end

      // R1: fresh reset, all outputs low while non-GPU levels are high
      do_reset();
      rd("R1 ctrl after reset", 8'h00, 32'h0);
      rd("R1 pmu after reset", 8'h14, 32'h0);
      timer_lvl = '1; mbox_lvl = '1; pmu_lvl = 1'b1;
      outs("R1 quiet", 4'b0000, 4'b0000);
      quiet();

      // R4: timer IRQ enables on core 1
      wr(8'h44, 32'h05);
      timer_lvl = 16'h0010;              // core1 timer0
      outs("R4 t0 irq", 4'b0010, 4'b0000);
      timer_lvl = 16'h0020;              // core1 timer1 (not enabled)
      outs("R4 t1 off", 4'b0000, 4'b0000);
      rd("R8 pend off", 8'h64, 32'h0);
      timer_lvl = 16'h0041;              // core1 timer2 and core0 timer0
      outs("R4 t2 irq", 4'b0010, 4'b0000);
      quiet();

      // R4: timer FIQ enable
      wr(8'h44, 32'h20);
      timer_lvl = 16'h0020;
      outs("R4 t1 fiq", 4'b0000, 4'b0010);
      rd("R8 pend t1", 8'h64, 32'h0000_0002);
      quiet();

      // R7: both enables on one timer
      wr(8'h44, 32'h11);
      timer_lvl = 16'h0010;
      outs("R7 both", 4'b0000, 4'b0010);
      rd("R7 pend kept", 8'h64, 32'h0000_0001);
      quiet();

      // R5: mailbox routes on core 2
      wr(8'h58, 32'h48);
      mbox_lvl = 16'h0800;               // core2 mailbox3
      outs("R5 mb3 irq", 4'b0100, 4'b0000);
      rd("R8 pend mb3", 8'h68, 32'h0000_0080);
      mbox_lvl = 16'h0400;               // core2 mailbox2
      outs("R5 mb2 fiq", 4'b0000, 4'b0100);
      rd("R8 pend mb2", 8'h68, 32'h0000_0040);
      quiet();

      // R6: GPU IRQ to core 2, FIQ to core 1
      wr(8'h0C, 32'h6);
      gpu_lvl = 1'b1;
      outs("R6 split", 4'b0100, 4'b0010);
      rd("R8 pend gpu c2", 8'h68, 32'h0000_0100);
      rd("R8 pend gpu c1", 8'h64, 32'h0000_0100);
      rd("R8 pend gpu c0", 8'h60, 32'h0);
      quiet();
      wr(8'h0C, 32'h5);
      gpu_lvl = 1'b1;
      outs("R7 gpu same core", 4'b0000, 4'b0010);
      quiet();

      // R3 / R7 / R8: PMU on core 0
      wr(8'h10, 32'h11);
      pmu_lvl = 1'b1;
      outs("R7 pmu both", 4'b0000, 4'b0001);
      wr(8'h14, 32'h10);
      outs("R3 pmu irq only", 4'b0001, 4'b0000);
      rd("R8 pend pmu", 8'h60, 32'h0000_0200);
      quiet();
      rd("R8 pend follows level", 8'h60, 32'h0);

      // R9: write to a pending word leaves routing intact
      wr(8'h64, 32'hFFFF_FFFF);
      rd("R9 tmr cfg kept", 8'h44, 32'h11);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule